// File: doc/BRIEF.md
# Two-Sensor Thermal Protection Controller

This block is the per-channel protection sequencer of a high-side power switch. It receives already digitized readings: a temperature from the hottest spot next to the power stage, a temperature from a cooler spot in the control area, and the load current. It also receives the channel's on/off command and a device-wide latch-mode pin. From these it drives the power-stage enable, chooses which of two current-limit thresholds is active, asks the regulation loop to clamp current, and raises a thermal-fault flag.

Two kinds of thermal event turn the stage off. The first is a large gradient between the two sensors, called power limitation. The second is an absolute over-temperature, called shutdown. After a power-limitation event the stage restarts once the gradient relaxes. After a shutdown it restarts once the hot spot cools below a separate restart level. The first shutdown also drops the block to the reduced current limit.

The fault flag has its own, lower clear level, so it stays up for as long as a faulty load keeps the channel cycling. With latch mode selected, the first thermal event keeps the stage off until the latch-mode pin is driven low. All temperature thresholds are 8-bit unsigned codes supplied from configuration registers.

Top module: `thermal_guard`

## Requirements
- R1: After a synchronous active-low reset, the fault flag, the reduced-limit select and the latch are all clear, and the state is running.
- R2: The stage enable equals the channel command AND not thermally off AND not latched. Driving the command low never clears the fault flag.
- R3: While running with the command high, a gradient (hot minus cool, taken as zero when hot is not above cool) strictly greater than the gradient threshold turns the stage off on the next cycle and sets the flag. Running resumes once the gradient is at or below the threshold.
- R4: While running with the command high, a hot reading strictly above the shutdown threshold turns the stage off. The stage stays off until the hot reading is strictly below the restart threshold. When both events are present together, shutdown takes priority.
- R5: `low_limit_sel` (1 = reduced limit) is set by entry into shutdown and never by a power-limitation event. It returns to 0 only on reset or when the command is low.
- R6: The fault flag is set at the start of either thermal event. It is cleared only while running and with the hot reading strictly below the flag-clear threshold, so a persisting fault keeps it asserted through repeated off/cool/restart cycles.
- R7: With `latch_en` high, a thermal event latches the stage off. Neither cooling nor toggling the command releases it. Driving `latch_en` low releases it on the next clock.
- R8: `clamp_req` is high exactly when the stage is enabled and the load current is at or above the active limit (high limit when `low_limit_sel`=0, low limit otherwise). An over-current alone never sets the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_in | input | 1 | Channel on command |
| latch_en | input | 1 | Device-wide latch mode; low releases a latch |
| hot_temp | input | TW | Hot-spot temperature code |
| cool_temp | input | TW | Cool-spot temperature code |
| load_cur | input | CW | Load current code |
| grad_thr | input | TW | Gradient threshold |
| shut_thr | input | TW | Shutdown threshold |
| restart_thr | input | TW | Restart threshold |
| flag_clr_thr | input | TW | Flag clear threshold |
| lim_high | input | CW | High current limit |
| lim_low | input | CW | Reduced current limit |
| stage_enable | output | 1 | Power-stage enable |
| low_limit_sel | output | 1 | 1 = reduced current limit active |
| clamp_req | output | 1 | Current clamp request |
| thermal_flag | output | 1 | Thermal fault flag |

## Verification
Current clamping and a thermal trip can fall in the same cycle. The bench drives a load above the limit together with an excessive gradient and checks two things. Before the edge, the clamp request is high and the flag is still low. After the edge, the stage is off, the clamp request has dropped, the flag is set, and the current limit stays high. A second overlap drives a gradient event and a shutdown together, and the bench judges from `low_limit_sel` going to 1 that shutdown took priority.

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_in,
  input  logic          latch_en,
  input  logic [TW-1:0] hot_temp,
  input  logic [TW-1:0] cool_temp,
  input  logic [CW-1:0] load_cur,
  input  logic [TW-1:0] grad_thr,
  input  logic [TW-1:0] shut_thr,
  input  logic [TW-1:0] restart_thr,
  input  logic [TW-1:0] flag_clr_thr,
  input  logic [CW-1:0] lim_high,
  input  logic [CW-1:0] lim_low,
  output logic          stage_enable,
  output logic          low_limit_sel,
  output logic          clamp_req,
  output logic          thermal_flag
);

  typedef enum logic [1:0] {ST_RUN, ST_PL, ST_SD} st_t;

  st_t           st;
  logic          latched_q;
  logic [TW-1:0] gradient;
  logic          grad_over, sd_over, trip, sd_entry;
  logic [CW-1:0] active_lim;

  assign gradient   = (hot_temp > cool_temp) ? hot_temp - cool_temp : '0;
  assign grad_over  = gradient > grad_thr;
  assign sd_over    = hot_temp > shut_thr;
  assign trip       = (st == ST_RUN) && chan_in && (sd_over || grad_over);
  assign sd_entry   = ((st == ST_RUN) && chan_in && sd_over) || ((st == ST_PL) && sd_over);
  assign active_lim = low_limit_sel ? lim_low : lim_high;

  assign stage_enable = chan_in && (st == ST_RUN) && !latched_q;
  assign clamp_req    = stage_enable && (load_cur >= active_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_RUN;
      latched_q     <= 1'b0;
      low_limit_sel <= 1'b0;
      thermal_flag  <= 1'b0;
    end else begin
      case (st)
        ST_RUN: if (chan_in && sd_over) st <= ST_SD;
                else if (chan_in && grad_over) st <= ST_PL;
        ST_PL:  if (sd_over) st <= ST_SD;
                else if (!grad_over) st <= ST_RUN;
        ST_SD:  if (hot_temp < restart_thr) st <= ST_RUN;
        default: st <= ST_RUN;
      endcase

      if (sd_entry) low_limit_sel <= 1'b1;
      else if (!chan_in) low_limit_sel <= 1'b0;

      if (trip) thermal_flag <= 1'b1;
      else if ((st == ST_RUN) && (hot_temp < flag_clr_thr)) thermal_flag <= 1'b0;

      if (!latch_en) latched_q <= 1'b0;
      else if (trip) latched_q <= 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!thermal_flag && !low_limit_sel && !latched_q));

  p_grad_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_enable && grad_over && !sd_over) |=> (!stage_enable && thermal_flag));

  p_sd_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_enable && sd_over) |=> (!stage_enable && low_limit_sel));

  p_pl_keeps_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RUN) && chan_in && grad_over && !sd_over && !low_limit_sel) |=> !low_limit_sel);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal_flag && (hot_temp >= flag_clr_thr)) |=> thermal_flag);

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && latch_en) |=> !stage_enable);

  p_clamp_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!thermal_flag && clamp_req && !grad_over && !sd_over) |=> !thermal_flag);

endmodule

// File: tb/thermal_guard_tb.sv
`timescale 1ns/1ps
module thermal_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_in = 1'b0, latch_en = 1'b0;
  logic [7:0] hot_temp = 8'd40, cool_temp = 8'd30, load_cur = 8'd0;
  logic [7:0] grad_thr = 8'd60, shut_thr = 8'd150, restart_thr = 8'd130, flag_clr_thr = 8'd110;
  logic [7:0] lim_high = 8'd90, lim_low = 8'd30;
  logic       stage_enable, low_limit_sel, clamp_req, thermal_flag;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  thermal_guard dut_i (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .latch_en(latch_en),
    .hot_temp(hot_temp), .cool_temp(cool_temp), .load_cur(load_cur),
    .grad_thr(grad_thr), .shut_thr(shut_thr), .restart_thr(restart_thr),
    .flag_clr_thr(flag_clr_thr), .lim_high(lim_high), .lim_low(lim_low),
    .stage_enable(stage_enable), .low_limit_sel(low_limit_sel),
    .clamp_req(clamp_req), .thermal_flag(thermal_flag));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic temps(input logic [7:0] h, input logic [7:0] c);
    hot_temp = h; cool_temp = c;
  endtask

  task automatic restore();
    chan_in = 0; latch_en = 0; load_cur = 0; temps(40, 30);
    tick(3);
  endtask

  task automatic t_reset();
    tick(2);
    chk("R1 flag", thermal_flag, 0);
    chk("R1 low_sel", low_limit_sel, 0);
    chk("R2 enable cmd low", stage_enable, 0);
    rst_n = 1; tick(1);
    chan_in = 1; #1;
    chk("R2 enable cmd high", stage_enable, 1);
    tick(1);
    chk("R2 enable steady", stage_enable, 1);
  endtask

  task automatic t_clamp();
    chan_in = 1; load_cur = 95; #1;
    chk("R8 clamp above high", clamp_req, 1);
    load_cur = 90; #1;
    chk("R8 clamp at limit", clamp_req, 1);
    tick(2);
    chk("R8 no flag", thermal_flag, 0);
    chk("R8 enable kept", stage_enable, 1);
    load_cur = 50; #1;
    chk("R8 clamp below", clamp_req, 0);
    restore();
  endtask

  task automatic t_grad();
    chan_in = 1; temps(20, 120); tick(1);
    chk("R3 negative gradient ignored", stage_enable, 1);
    temps(90, 30); tick(1);
    chk("R3 gradient at threshold", stage_enable, 1);
    temps(100, 30); tick(1);
    chk("R3 off on gradient", stage_enable, 0);
    chk("R6 flag on gradient", thermal_flag, 1);
    chk("R5 no low on gradient", low_limit_sel, 0);
    chan_in = 0; tick(2);
    chk("R2 low cmd keeps flag", thermal_flag, 1);
    chan_in = 1; temps(85, 30); tick(1);
    chk("R3 resume", stage_enable, 1);
    chk("R6 flag held one cycle", thermal_flag, 1);
    tick(1);
    chk("R6 flag cleared", thermal_flag, 0);
    restore();
  endtask

  task automatic t_shutdown();
    chan_in = 1; temps(160, 120); tick(1);
    chk("R4 off on shutdown", stage_enable, 0);
    chk("R5 low selected", low_limit_sel, 1);
    chk("R6 flag on shutdown", thermal_flag, 1);
    temps(135, 120); tick(1);
    chk("R4 stays off above restart", stage_enable, 0);
    temps(130, 120); tick(1);
    chk("R4 stays off at restart", stage_enable, 0);
    temps(125, 120); tick(1);
    chk("R4 restart", stage_enable, 1);
    chk("R6 flag above clear", thermal_flag, 1);
    load_cur = 35; #1;
    chk("R8 clamp at low limit", clamp_req, 1);
    load_cur = 0;
    temps(155, 120); tick(1);
    chk("R6 re-trip off", stage_enable, 0);
    chk("R6 flag through cycling", thermal_flag, 1);
    temps(100, 90); tick(1);
    chk("R4 restart again", stage_enable, 1);
    chk("R6 flag still set", thermal_flag, 1);
    tick(1);
    chk("R6 flag cleared cool", thermal_flag, 0);
    chk("R5 low kept while cmd high", low_limit_sel, 1);
    chan_in = 0; tick(1);
    chk("R5 low released by cmd low", low_limit_sel, 0);
    restore();
  endtask

  task automatic t_latch();
    latch_en = 1; chan_in = 1; temps(100, 30); tick(1);
    chk("R7 latched off", stage_enable, 0);
    temps(40, 30); tick(3);
    chk("R7 cooling no release", stage_enable, 0);
    chan_in = 0; tick(1); chan_in = 1; tick(1);
    chk("R7 toggle no release", stage_enable, 0);
    latch_en = 0; tick(1);
    chk("R7 release by pin low", stage_enable, 1);
    restore();
  endtask

  task automatic t_overlap();
    chan_in = 1; load_cur = 95; temps(100, 30); #1;
    chk("R8 clamp before trip", clamp_req, 1);
    chk("R8 flag low before trip", thermal_flag, 0);
    tick(1);
    chk("R3 off with clamp", stage_enable, 0);
    chk("R8 clamp dropped", clamp_req, 0);
    chk("R6 flag set overlap", thermal_flag, 1);
    chk("R5 limit high overlap", low_limit_sel, 0);
    restore();
    chan_in = 1; temps(200, 30); tick(1);
    chk("R4 shutdown priority", low_limit_sel, 1);
    chk("R4 off both events", stage_enable, 0);
    restore();
  endtask

  initial begin
    t_reset();
    t_clamp();
    t_grad();
    t_shutdown();
    t_latch();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule